// File: doc/BRIEF.md
# Erase-Block Lock Guard

The block keeps one lock bit for each erase block of a flash array, along with a protect state. The protect state decides whether those bits are trusted yet. A command sequencer asks it whether a byte write, a single-block erase or an erase of all unlocked blocks may proceed. For the erase-all case it also walks the array and hands out the unlocked block indices one at a time. A denied answer is turned into an error status bit by the sequencer, and the array is left untouched.

After every reset the lock bits are distrusted. Every write and single-block erase is refused until the sequencer issues a protect-confirm strobe. The first completed erase-all sweep also ends this state. The sweep itself never waits for confirmation, because it always reads the real lock bits.

The lock bits model non-volatile cells. A separate power-on input preloads them from a parameter, and the ordinary reset leaves them alone.

Top module: `blk_guard`

## Requirements
- R1: While `por_n` is low, the lock bits load `LOCK_INIT`, where bit i is the lock of block i and 1 means locked. The default is 32'h9000_00F3.
- R2: From a low `rst_n` until the first protect-confirm or the first completed sweep, every query with op 0 (byte write) or op 1 (single-block erase) returns `q_allow_o` = 0 for every block.
- R3: Once protect is confirmed, op 0 and op 1 queries return `q_allow_o` = 1 exactly when the queried block's lock bit is 0.
- R4: A `lock_set_i` strobe sets the lock bit of block `cmd_blk_i` from the next cycle on, leaves every other bit unchanged, and survives `rst_n`.
- R5: A query with op 2 (erase all unlocked) returns `q_allow_o` = 1 at all times, including before protect is confirmed.
- R6: One cycle after `ea_start_i`, the sweep presents on `ea_blk_o` with `ea_valid_o` = 1 the lowest-indexed block whose true lock bit is 0. Each `ea_step_i` advances it to the next higher unlocked block, skipping locked ones.
- R7: When no unlocked block remains, `ea_done_o` is 1 for exactly one cycle with `ea_valid_o` = 0. From the next cycle, write and erase queries follow the lock bits.
- R8: A low `rst_n` ends any sweep at once, with `ea_valid_o` and `ea_done_o` both at 0, and protect returns to the distrusted state.
- R9: A query with op 3 (reserved) returns `q_allow_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on preload of the lock bits, active low, asynchronous |
| rst_n | input | 1 | Device reset, active low, asynchronous; leaves the lock bits alone |
| lock_set_i | input | 1 | Strobe: lock block `cmd_blk_i` |
| wp_set_i | input | 1 | Strobe: protect confirm, lock bits become trusted |
| cmd_blk_i | input | 5 | Block index for `lock_set_i` |
| q_op_i | input | 2 | Query op: 0 write, 1 erase one, 2 erase all, 3 reserved |
| q_blk_i | input | 5 | Query block index |
| q_allow_o | output | 1 | 1 allows the queried operation, 0 denies it |
| ea_start_i | input | 1 | Start an erase-all sweep at block 0 |
| ea_step_i | input | 1 | Advance the sweep past the presented block |
| ea_valid_o | output | 1 | `ea_blk_o` holds an unlocked block to erase |
| ea_blk_o | output | 5 | Block presented by the sweep |
| ea_done_o | output | 1 | One-cycle pulse: sweep finished |

## Verification
The bench first queries every block for write and erase straight after reset. A design that trusted the bits too early would allow the unlocked blocks there. It then runs a sweep before any confirmation, which checks two things: a design that applied the all-locked view to the sweep would report done at once, and one that missed locked neighbours would present a locked block or skip to the wrong index. It pulls reset in the middle of a sweep, expecting the sweep to vanish and the lock bits to come back unchanged. A design that cleared the bits on reset would then allow a block that was locked by command.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [1:0] {
    OP_WRITE     = 2'd0,
    OP_ERASE_ONE = 2'd1,
    OP_ERASE_ALL = 2'd2,
    OP_RSVD      = 2'd3
  } guard_op_e;

  // Permission rule for a single query.
  function automatic logic grant(guard_op_e op, logic trusted, logic locked);
    case (op)
      OP_WRITE, OP_ERASE_ONE: grant = trusted && !locked;
      OP_ERASE_ALL:           grant = 1'b1;
      default:                grant = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/guard_lockbank.sv
module guard_lockbank #(
  parameter int IW = 5,
  parameter int NB = 1 << IW,
  parameter logic [NB-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          set_i,
  input  logic [IW-1:0] idx_i,
  output logic [NB-1:0] lock_o
);

  logic [NB-1:0] lock_q;

  // Only power-on reloads the cells; device reset has no path here.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     lock_q <= INIT;
    else if (set_i) lock_q[idx_i] <= 1'b1;
  end

  assign lock_o = lock_q;

endmodule

// File: rtl/guard_permit.sv
module guard_permit #(
  parameter int IW = 5,
  parameter int NB = 1 << IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_set_i,
  input  logic          sweep_done_i,
  input  logic [1:0]    op_i,
  input  logic [IW-1:0] blk_i,
  input  logic [NB-1:0] lock_i,
  output logic          allow_o,
  output logic          trusted_o
);
  import guard_pkg::*;

  logic trusted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         trusted_q <= 1'b0;
    else if (wp_set_i || sweep_done_i)  trusted_q <= 1'b1;
  end

  assign allow_o   = grant(guard_op_e'(op_i), trusted_q, lock_i[blk_i]);
  assign trusted_o = trusted_q;

endmodule

// File: rtl/guard_sweep.sv
module guard_sweep #(
  parameter int IW = 5,
  parameter int NB = 1 << IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          step_i,
  input  logic [NB-1:0] lock_i,
  output logic          valid_o,
  output logic [IW-1:0] blk_o,
  output logic          done_o
);

  // Lowest unlocked index at or above 'from'; NB when none is left.
  function automatic logic [IW:0] seek(logic [NB-1:0] locks, logic [IW:0] from);
    seek = (IW+1)'(NB);
    for (int i = NB - 1; i >= 0; i--)
      if ((IW+1)'(i) >= from && !locks[i]) seek = (IW+1)'(i);
  endfunction

  logic          active_q;
  logic [IW:0]   cur_q;
  logic [IW:0]   hit;
  logic          found;

  assign hit   = seek(lock_i, cur_q);
  assign found = !hit[IW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cur_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cur_q    <= '0;
    end else if (active_q) begin
      if (!found)      active_q <= 1'b0;
      else if (step_i) cur_q    <= hit + 1'b1;
    end
  end

  assign valid_o = active_q && found;
  assign done_o  = active_q && !found;
  assign blk_o   = hit[IW-1:0];

endmodule

// File: rtl/blk_guard.sv
module blk_guard #(
  parameter int BLK_IDX_W = 5,
  parameter logic [(1 << BLK_IDX_W)-1:0] LOCK_INIT = 32'h9000_00F3
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_n,
  input  logic                 lock_set_i,
  input  logic                 wp_set_i,
  input  logic [BLK_IDX_W-1:0] cmd_blk_i,
  input  logic [1:0]           q_op_i,
  input  logic [BLK_IDX_W-1:0] q_blk_i,
  output logic                 q_allow_o,
  input  logic                 ea_start_i,
  input  logic                 ea_step_i,
  output logic                 ea_valid_o,
  output logic [BLK_IDX_W-1:0] ea_blk_o,
  output logic                 ea_done_o
);
  localparam int NB = 1 << BLK_IDX_W;

  logic [NB-1:0] lock_q;
  logic          protect_open;
  logic          sweep_done;

  guard_lockbank #(.IW(BLK_IDX_W), .NB(NB), .INIT(LOCK_INIT)) u_bank (
    .clk(clk), .por_n(por_n), .set_i(lock_set_i), .idx_i(cmd_blk_i), .lock_o(lock_q)
  );

  guard_sweep #(.IW(BLK_IDX_W), .NB(NB)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start_i(ea_start_i), .step_i(ea_step_i),
    .lock_i(lock_q), .valid_o(ea_valid_o), .blk_o(ea_blk_o), .done_o(sweep_done)
  );

  guard_permit #(.IW(BLK_IDX_W), .NB(NB)) u_permit (
    .clk(clk), .rst_n(rst_n), .wp_set_i(wp_set_i), .sweep_done_i(sweep_done),
    .op_i(q_op_i), .blk_i(q_blk_i), .lock_i(lock_q),
    .allow_o(q_allow_o), .trusted_o(protect_open)
  );

  assign ea_done_o = sweep_done;

endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
  parameter int IW = 5,
  parameter int NB = 1 << IW
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          lock_set_i,
  input logic [IW-1:0] cmd_blk_i,
  input logic [1:0]    q_op_i,
  input logic [IW-1:0] q_blk_i,
  input logic          q_allow_o,
  input logic          ea_start_i,
  input logic          ea_step_i,
  input logic          ea_valid_o,
  input logic [IW-1:0] ea_blk_o,
  input logic          ea_done_o,
  input logic [NB-1:0] lock_q,
  input logic          protect_open
);

  // R2
  deny_untrusted_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!protect_open && q_op_i <= 2'd1) |-> !q_allow_o);

  // R3
  follow_bits_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (protect_open && q_op_i <= 2'd1) |-> (q_allow_o == !lock_q[q_blk_i]));

  // R4
  lock_sticks_chk: assert property (@(posedge clk) disable iff (!por_n)
    lock_set_i |=> lock_q[$past(cmd_blk_i)]);

  // R5
  sweep_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (q_op_i == 2'd2) |-> q_allow_o);

  // R6
  sweep_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ea_valid_o |-> !lock_q[ea_blk_o]);

  // R6
  sweep_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (ea_valid_o && ea_step_i && !ea_start_i) |=> (!ea_valid_o || ea_blk_o > $past(ea_blk_o)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (ea_done_o && !ea_start_i) |=> (protect_open && !ea_done_o));

  // R8
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (!ea_valid_o && !ea_done_o);
  end

endmodule

bind blk_guard guard_chk #(.IW(BLK_IDX_W), .NB(1 << BLK_IDX_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .lock_set_i(lock_set_i),
  .cmd_blk_i(cmd_blk_i), .q_op_i(q_op_i), .q_blk_i(q_blk_i), .q_allow_o(q_allow_o),
  .ea_start_i(ea_start_i), .ea_step_i(ea_step_i), .ea_valid_o(ea_valid_o),
  .ea_blk_o(ea_blk_o), .ea_done_o(ea_done_o), .lock_q(lock_q),
  .protect_open(protect_open)
);

// File: tb/test_blk_guard.sv
`timescale 1ns/1ps
module test_blk_guard;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       por_n, rst_n, lock_set_i, wp_set_i, ea_start_i, ea_step_i;
  logic [4:0] cmd_blk_i, q_blk_i, ea_blk_o;
  logic [1:0] q_op_i;
  logic       q_allow_o, ea_valid_o, ea_done_o;

  blk_guard i_blk_guard (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .lock_set_i(lock_set_i),
    .wp_set_i(wp_set_i), .cmd_blk_i(cmd_blk_i), .q_op_i(q_op_i), .q_blk_i(q_blk_i),
    .q_allow_o(q_allow_o), .ea_start_i(ea_start_i), .ea_step_i(ea_step_i),
    .ea_valid_o(ea_valid_o), .ea_blk_o(ea_blk_o), .ea_done_o(ea_done_o)
  );

  // kind 0: q_allow_o; kind 1: valid ? 64+blk : 0; kind 2: ea_done_o
  typedef struct { int kind; int exp; string req; string what; } item_t;
  item_t sb[$];
  int    n_chk = 0, n_fail = 0;
  event  smp;

  logic [31:0] m_lock;
  bit          m_open;

  always @(smp) begin
    item_t it;
    int    act;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      case (it.kind)
        0:       act = int'(q_allow_o);
        1:       act = ea_valid_o ? 64 + int'(ea_blk_o) : 0;
        default: act = int'(ea_done_o);
      endcase
      n_chk++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s %s: actual %0d expected %0d", it.req, it.what, act, it.exp);
      end
    end
  end

  task automatic expect_item(int kind, int exp, string req, string what);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req; it.what = what;
    sb.push_back(it);
    #1;
    ->smp;
    #0.1;
  endtask

  function automatic int model_grant(int op, int blk);
    if (op == 2) return 1;
    if (op == 3) return 0;
    return (m_open && !m_lock[blk]) ? 1 : 0;
  endfunction

  task automatic query(int op, int blk, string req);
    @(negedge clk);
    q_op_i = op[1:0]; q_blk_i = blk[4:0];
    expect_item(0, model_grant(op, blk), req, $sformatf("op%0d blk%0d", op, blk));
  endtask

  task automatic pulse_wp();
    @(negedge clk); wp_set_i = 1'b1;
    @(negedge clk); wp_set_i = 1'b0;
    m_open = 1'b1;
  endtask

  task automatic pulse_lock(int blk);
    @(negedge clk); lock_set_i = 1'b1; cmd_blk_i = blk[4:0];
    @(negedge clk); lock_set_i = 1'b0;
    m_lock[blk] = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    expect_item(1, 0, "R8", "valid in reset");
    expect_item(2, 0, "R8", "done in reset");
    @(negedge clk); rst_n = 1'b1;
    m_open = 1'b0;
  endtask

  task automatic sweep_all(string req);
    @(negedge clk); ea_start_i = 1'b1;
    @(negedge clk); ea_start_i = 1'b0;
    for (int b = 0; b < 32; b++) begin
      if (!m_lock[b]) begin
        expect_item(1, 64 + b, req, $sformatf("sweep presents blk%0d", b));
        ea_step_i = 1'b1;
        @(negedge clk); ea_step_i = 1'b0;
      end
    end
    expect_item(2, 1, "R7", "done pulse");
    expect_item(1, 0, "R7", "no valid at done");
    @(negedge clk);
    expect_item(2, 0, "R7", "done only one cycle");
    m_open = 1'b1;
  endtask

  bit finished = 1'b0;

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    por_n = 0; rst_n = 0; lock_set_i = 0; wp_set_i = 0; ea_start_i = 0; ea_step_i = 0;
    cmd_blk_i = 0; q_op_i = 0; q_blk_i = 0;
    m_lock = 32'h9000_00F3; m_open = 0;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;

    // reset state
    expect_item(1, 0, "R8", "valid after reset");
    expect_item(2, 0, "R8", "done after reset");
    for (int b = 0; b < 32; b++) begin
      query(0, b, "R2");
      query(1, b, "R2");
    end
    query(2, 0, "R5");
    query(2, 31, "R5");
    query(3, 3, "R9");

    // sweep before confirmation uses the true bits
    sweep_all("R6");
    for (int b = 0; b < 32; b++) query(0, b, "R7");

    // reset keeps bits, distrusts them again
    do_reset();
    query(0, 2, "R2");
    query(1, 3, "R2");
    pulse_wp();
    for (int b = 0; b < 32; b++) query(1, b, "R1");
    query(0, 9, "R3");
    query(0, 31, "R3");

    // lock a block; survives reset
    pulse_lock(2);
    query(0, 2, "R4");
    query(0, 3, "R4");
    do_reset();
    pulse_wp();
    query(1, 2, "R4");
    query(1, 3, "R4");
    query(3, 3, "R9");

    // reset in the middle of a sweep
    @(negedge clk); ea_start_i = 1'b1;
    @(negedge clk); ea_start_i = 1'b0;
    expect_item(1, 64 + 3, "R6", "first unlocked after lock");
    ea_step_i = 1'b1;
    @(negedge clk); ea_step_i = 1'b0;
    expect_item(1, 64 + 8, "R6", "skip locked 4..7");
    do_reset();
    expect_item(1, 0, "R8", "sweep gone after reset");
    query(0, 3, "R8");

    // full sweep again with the new lock pattern
    sweep_all("R6");
    query(0, 8, "R7");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule